// File: doc/BRIEF.md
# Partial-Word Byte Merge Unit

This block does the byte-lane arithmetic for left and right partial-word transfers in a big-endian machine. Software moves a 32-bit value that is not word aligned with two instructions. One handles the bytes on the left side of the unaligned address and the other handles the bytes on its right side. Each instruction touches only the aligned word that holds its own byte. The unit does not read or write memory. It is given the operand words and returns the merged word. For a store it also returns a per-byte write mask.

For a load, the unit takes the aligned memory word and the current destination register value. It moves the memory bytes that belong to the register into place and leaves the other register bytes unchanged. For a store, it takes the register value and the current memory word. It moves the register bytes into the memory lanes they cover and keeps the other memory bytes. The byte offset is the low two address bits. Address generation and the memory access are done by neighbouring logic. The unit is purely combinational.

Top module: `partial_word_merge`

## Requirements
- R1: Lane k (k = 0..3) is bits [31-8k : 24-8k], so lane 0 is the most significant byte. `offset_i` is the low two bits of the effective address and selects lane k of the aligned word. For load-left (op 0) at offset k, result lanes 0..3-k take memory lanes k..3, and result lanes 4-k..3 keep the old register lanes.
- R2: For load-right (op 1) at offset k, result lanes 3-k..3 take memory lanes 0..k, and result lanes 0..2-k keep the old register lanes.
- R3: For store-left (op 2) at offset k, result lanes k..3 take register lanes 0..3-k, and result lanes 0..k-1 keep the old memory lanes.
- R4: For store-right (op 3) at offset k, result lanes 0..k take register lanes 3-k..3, and result lanes k+1..3 keep the old memory lanes.
- R5: `byte_en_o[i]` refers to lane i. For stores it is set exactly for the lanes the store writes: lanes k..3 for store-left and lanes 0..k for store-right. For loads it is all zero.
- R6: Load-left at offset 0 and load-right at offset 3 replace the whole register with the memory word. Store-left at offset 0 and store-right at offset 3 write the whole register and enable all four lanes. No shift leaks bits across the word edge.
- R7: In every mode, each result lane that is not written is equal to the same lane of the kept word. The kept word is the register for loads and the memory word for stores.
- R8: A left operation at byte address A followed by a right operation at A+3 moves the four bytes at A..A+3 exactly, for every alignment of A. For stores, all other memory bytes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| offset_i | input | 2 | Low address bits: byte lane within the aligned word |
| mem_word_i | input | 32 | Aligned memory word holding the addressed byte |
| reg_word_i | input | 32 | Register value (old destination for loads, data for stores) |
| merged_o | output | 32 | New register value (loads) or new memory word (stores) |
| byte_en_o | output | 4 | Per-lane write mask for stores; bit i belongs to lane i |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `merged_o` or `byte_en_o`. The bench drives a stimulus on a rising edge and reads the outputs on the following falling edge, half a period later. Each step is complete within one cycle. The paired left/right sequences run as two such steps, and the second step uses the output of the first as its input. This is the only cross-cycle dependency, and it goes through the bench's own byte array and register copy, not through any state in the design.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'd0,
    OP_LOAD_RIGHT  = 2'd1,
    OP_STORE_LEFT  = 2'd2,
    OP_STORE_RIGHT = 2'd3
  } merge_op_e;

  // SHIFT_UP  : destination lane j is fed from source lane j+s
  // SHIFT_DOWN: destination lane j is fed from source lane j-s
  typedef enum logic {
    SHIFT_UP   = 1'b0,
    SHIFT_DOWN = 1'b1
  } lane_dir_e;

endpackage

// File: rtl/pwm_shift_ctrl.sv
module pwm_shift_ctrl
  import pwm_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [1:0]       op_i,
  input  logic [OFF_W-1:0] offset_i,
  output lane_dir_e        dir_o,
  output logic [OFF_W-1:0] shift_o,
  output logic             is_store_o
);

  localparam logic [OFF_W-1:0] LAST_LANE = OFF_W'(LANES - 1);

  logic [OFF_W-1:0] mirror_off;

  always_comb begin
    mirror_off = LAST_LANE - offset_i;
  end

  always_comb begin
    dir_o      = SHIFT_UP;
    shift_o    = offset_i;
    is_store_o = 1'b0;
    unique case (merge_op_e'(op_i))
      OP_LOAD_LEFT: begin
        dir_o   = SHIFT_UP;
        shift_o = offset_i;
      end
      OP_LOAD_RIGHT: begin
        dir_o   = SHIFT_DOWN;
        shift_o = mirror_off;
      end
      OP_STORE_LEFT: begin
        dir_o      = SHIFT_DOWN;
        shift_o    = offset_i;
        is_store_o = 1'b1;
      end
      OP_STORE_RIGHT: begin
        dir_o      = SHIFT_UP;
        shift_o    = mirror_off;
        is_store_o = 1'b1;
      end
      default: begin
        dir_o      = SHIFT_UP;
        shift_o    = offset_i;
        is_store_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
  import pwm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int IDX    = 0,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] src_word_i,
  input  logic [LANE_W-1:0] keep_lane_i,
  input  lane_dir_e         dir_i,
  input  logic [OFF_W-1:0]  shift_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              take_o
);

  int shift_amt;
  int src_idx;

  always_comb begin
    shift_amt = int'(shift_i);
    if (dir_i == SHIFT_UP) begin
      src_idx = IDX + shift_amt;
      take_o  = (src_idx <= LANES - 1);
    end else begin
      src_idx = IDX - shift_amt;
      take_o  = (IDX >= shift_amt);
    end
  end

  always_comb begin
    lane_o = keep_lane_i;
    if (take_o) begin
      for (int c = 0; c < LANES; c++) begin
        if (c == src_idx) begin
          lane_o = src_word_i[(LANES-1-c)*LANE_W +: LANE_W];
        end
      end
    end
  end

endmodule

// File: rtl/partial_word_merge.sv
module partial_word_merge
  import pwm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [1:0]        op_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [WORD_W-1:0] mem_word_i,
  input  logic [WORD_W-1:0] reg_word_i,
  output logic [WORD_W-1:0] merged_o,
  output logic [LANES-1:0]  byte_en_o
);

  lane_dir_e        dir;
  logic [OFF_W-1:0] shift;
  logic             is_store;
  logic [WORD_W-1:0] src_word;
  logic [WORD_W-1:0] keep_word;
  logic [LANES-1:0]  take;

  pwm_shift_ctrl #(.LANES(LANES)) ctrl_i (
    .op_i       (op_i),
    .offset_i   (offset_i),
    .dir_o      (dir),
    .shift_o    (shift),
    .is_store_o (is_store)
  );

  // Loads pull bytes out of memory into the register; stores do the reverse.
  always_comb begin
    if (is_store) begin
      src_word  = reg_word_i;
      keep_word = mem_word_i;
    end else begin
      src_word  = mem_word_i;
      keep_word = reg_word_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LSB = (LANES - 1 - g) * LANE_W;
    pwm_lane #(.LANES(LANES), .LANE_W(LANE_W), .IDX(g)) lane_i (
      .src_word_i  (src_word),
      .keep_lane_i (keep_word[LSB +: LANE_W]),
      .dir_i       (dir),
      .shift_i     (shift),
      .lane_o      (merged_o[LSB +: LANE_W]),
      .take_o      (take[g])
    );
  end

  always_comb begin
    byte_en_o = is_store ? take : '0;
  end

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input logic [1:0]        op_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [WORD_W-1:0] mem_word_i,
  input logic [WORD_W-1:0] reg_word_i,
  input logic [WORD_W-1:0] merged_o,
  input logic [LANES-1:0]  byte_en_o
);

  always_comb begin
    if (op_i < 2'd2) begin
      // R5
      load_no_enable_chk: assert (byte_en_o == '0)
        else $error("byte enable active on a load");
    end else if (op_i == 2'd2) begin
      // R5
      store_left_count_chk: assert ($countones(byte_en_o) == LANES - int'(offset_i))
        else $error("store-left enable count wrong");
    end else begin
      // R5
      store_right_count_chk: assert ($countones(byte_en_o) == int'(offset_i) + 1)
        else $error("store-right enable count wrong");
    end
  end

  always_comb begin
    if ((op_i == 2'd0 && offset_i == '0) || (op_i == 2'd1 && offset_i == OFF_W'(LANES - 1))) begin
      // R6
      full_load_chk: assert (merged_o == mem_word_i)
        else $error("full-width load did not copy memory word");
    end
  end

  always_comb begin
    if (op_i >= 2'd2) begin
      for (int i = 0; i < LANES; i++) begin
        if (!byte_en_o[i]) begin
          // R7
          kept_lane_chk: assert (merged_o[(LANES-1-i)*LANE_W +: LANE_W] ==
                                 mem_word_i[(LANES-1-i)*LANE_W +: LANE_W])
            else $error("unwritten store lane changed");
        end
      end
    end
  end

  always_comb begin
    if (op_i == 2'd2) begin
      // R3
      store_left_edge_chk: assert (merged_o[(LANES-1-int'(offset_i))*LANE_W +: LANE_W] ==
                                   reg_word_i[WORD_W-1 -: LANE_W])
        else $error("store-left first lane wrong");
    end
  end

endmodule

bind partial_word_merge pwm_checker #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .op_i       (op_i),
  .offset_i   (offset_i),
  .mem_word_i (mem_word_i),
  .reg_word_i (reg_word_i),
  .merged_o   (merged_o),
  .byte_en_o  (byte_en_o)
);

// File: tb/partial_word_merge_tb.sv
module partial_word_merge_tb_top;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  off;
    logic [31:0] mem;
    logic [31:0] rg;
    logic [31:0] exp;
    logic [3:0]  be;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    // R1 load-left
    '{2'd0, 2'd0, 32'h11223344, 32'hAABBCCDD, 32'h11223344, 4'b0000},
    '{2'd0, 2'd1, 32'h11223344, 32'hAABBCCDD, 32'h223344DD, 4'b0000},
    '{2'd0, 2'd2, 32'h11223344, 32'hAABBCCDD, 32'h3344CCDD, 4'b0000},
    '{2'd0, 2'd3, 32'h11223344, 32'hAABBCCDD, 32'h44BBCCDD, 4'b0000},
    // R2 load-right
    '{2'd1, 2'd0, 32'h11223344, 32'hAABBCCDD, 32'hAABBCC11, 4'b0000},
    '{2'd1, 2'd1, 32'h11223344, 32'hAABBCCDD, 32'hAABB1122, 4'b0000},
    '{2'd1, 2'd2, 32'h11223344, 32'hAABBCCDD, 32'hAA112233, 4'b0000},
    '{2'd1, 2'd3, 32'h11223344, 32'hAABBCCDD, 32'h11223344, 4'b0000},
    // R3 store-left
    '{2'd2, 2'd0, 32'hAABBCCDD, 32'h11223344, 32'h11223344, 4'b1111},
    '{2'd2, 2'd1, 32'hAABBCCDD, 32'h11223344, 32'hAA112233, 4'b1110},
    '{2'd2, 2'd2, 32'hAABBCCDD, 32'h11223344, 32'hAABB1122, 4'b1100},
    '{2'd2, 2'd3, 32'hAABBCCDD, 32'h11223344, 32'hAABBCC11, 4'b1000},
    // R4 store-right
    '{2'd3, 2'd0, 32'hAABBCCDD, 32'h11223344, 32'h44BBCCDD, 4'b0001},
    '{2'd3, 2'd1, 32'hAABBCCDD, 32'h11223344, 32'h3344CCDD, 4'b0011},
    '{2'd3, 2'd2, 32'hAABBCCDD, 32'h11223344, 32'h223344DD, 4'b0111},
    '{2'd3, 2'd3, 32'hAABBCCDD, 32'h11223344, 32'h11223344, 4'b1111}
  };

  logic        clk;
  logic [1:0]  op;
  logic [1:0]  off;
  logic [31:0] mem_w;
  logic [31:0] reg_w;
  logic [31:0] merged;
  logic [3:0]  be;

  int checks;
  int fails;
  bit done;

  logic [7:0] arr [16];
  logic [7:0] ref_arr [16];

  partial_word_merge dut_i (
    .op_i       (op),
    .offset_i   (off),
    .mem_word_i (mem_w),
    .reg_word_i (reg_w),
    .merged_o   (merged),
    .byte_en_o  (be)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic apply(input logic [1:0] o, input logic [1:0] k,
                       input logic [31:0] m, input logic [31:0] r);
    @(posedge clk);
    op = o; off = k; mem_w = m; reg_w = r;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int base);
    return {arr[base], arr[base+1], arr[base+2], arr[base+3]};
  endfunction

  task automatic init_arrays();
    for (int i = 0; i < 16; i++) begin
      arr[i]     = 8'h50 + 8'(i * 7);
      ref_arr[i] = arr[i];
    end
  endtask

  task automatic commit(input int base);
    for (int i = 0; i < 4; i++)
      if (be[i]) arr[base+i] = merged[31-8*i -: 8];
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    op = '0; off = '0; mem_w = '0; reg_w = '0;
    repeat (2) @(posedge clk);

    // R1 R2 R3 R4 R5 R6: table walk, word and byte enables
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].op, VECS[v].off, VECS[v].mem, VECS[v].rg);
      check($sformatf("R%0d_word vec%0d", int'(VECS[v].op) + 1, v), merged, VECS[v].exp);
      check($sformatf("R5_enable vec%0d", v), {28'd0, be}, {28'd0, VECS[v].be});
    end

    // R7: load lanes beyond the moved bytes keep the register
    apply(2'd0, 2'd2, 32'h00000000, 32'hFFFFFFFF);
    check("R7 load-left keep", merged, 32'h0000FFFF);
    apply(2'd1, 2'd0, 32'h00000000, 32'hFFFFFFFF);
    check("R7 load-right keep", merged, 32'hFFFFFF00);
    apply(2'd3, 2'd1, 32'h00000000, 32'hFFFFFFFF);
    check("R7 store-right keep", merged, 32'hFFFF0000);

    // R8: unaligned load pairs against a reference byte array
    for (int a = 0; a < 9; a++) begin
      logic [31:0] r1;
      init_arrays();
      apply(2'd0, 2'(a), word_at(a & ~3), 32'hDEADBEEF);
      r1 = merged;
      apply(2'd1, 2'(a + 3), word_at((a + 3) & ~3), r1);
      check($sformatf("R8 load pair addr %0d", a), merged,
            {ref_arr[a], ref_arr[a+1], ref_arr[a+2], ref_arr[a+3]});
    end

    // R8: unaligned store pairs; the whole array must match the reference
    for (int a = 0; a < 9; a++) begin
      logic [31:0] val;
      logic [31:0] diff;
      val = 32'hC0DE0000 | 32'(a * 32'h0101);
      init_arrays();
      for (int i = 0; i < 4; i++) ref_arr[a+i] = val[31-8*i -: 8];
      apply(2'd2, 2'(a), word_at(a & ~3), val);
      commit(a & ~3);
      apply(2'd3, 2'(a + 3), word_at((a + 3) & ~3), val);
      commit((a + 3) & ~3);
      diff = '0;
      for (int i = 0; i < 16; i++)
        if (arr[i] !== ref_arr[i]) diff = diff + 1;
      check($sformatf("R8 store pair addr %0d mismatched bytes", a), diff, 32'd0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule